// File: doc/BRIEF.md
# Nonvolatile Register Store Controller

This block keeps the setting storage behind a bank of digitally adjustable potentiometer channels. Each channel owns one live wiper register, which sets its tap position, and a small set of stored slots that stand in for nonvolatile memory. A command decoder ahead of this block turns serial frames into single-cycle command pulses. It also passes along the chip-select and write-protect pins. The controller updates wipers at once. It moves values between wipers and stored slots. It holds every store to the slots until the frame is closed.

A store request does not touch the slots when it arrives. It is held as pending and becomes a timed write cycle only when chip select returns high. While write-protect is active the request is refused, and if write-protect drops before chip select rises the pending store is cancelled. Once the cycle has begun it runs to the end. A write-in-progress flag is high for a parameter number of clock cycles. A hard reset sets every slot to an initial value. A soft reset keeps the slots and reloads each wiper from slot 0 of its own channel.

Top module: `nvstore_ctrl`

## Requirements
- R1: After hard reset every stored slot reads DATA_INIT, every wiper equals DATA_INIT (its own slot 0), and `wip` is 0.
- R2: A one-cycle `soft_rst` reloads each wiper from slot 0 of its own channel on the next edge and leaves every stored slot unchanged.
- R3: Opcode 1 (wiper write) sets wiper `cmd_ch` to `cmd_data` on the edge that samples it. This happens whatever the state of `wp_n` and `wip`.
- R4: Opcodes 2 (slot write), 4 (wiper to slot, one channel) and 6 (all wipers to slot `cmd_reg`) are accepted only while `cs_n` is 0. They leave the slots and `wip` unchanged until `cs_n` rises.
- R5: A rising `cs_n` with an accepted store pending raises `wip` on that edge. `wip` then stays 1 for exactly WRITE_CYCLES cycles, and the new slot values read back on the edge where it falls.
- R6: A store command sampled while `wp_n` is 0 is dropped. If `wp_n` is 0 in any cycle between acceptance and the `cs_n` rise, the pending store is cancelled and no write cycle starts.
- R7: `wp_n` going low while `wip` is 1 neither shortens the write cycle nor prevents its values from landing.
- R8: Store commands sampled while `wip` is 1 are ignored, and a later `cs_n` rise starts no cycle for them.
- R9: Opcode 3 copies slot `cmd_reg` of channel `cmd_ch` into that channel's wiper on the next edge, without a write cycle.
- R10: Opcode 5 copies slot `cmd_reg` of every channel into that channel's wiper on the next edge, without a write cycle.
- R11: Opcode 6 stores the wiper value of every channel, as sampled with the command, into slot `cmd_reg` of that same channel.
- R12: Opcode 4 stores the wiper of `cmd_ch`, as sampled with the command, into slot `cmd_reg` of that channel and into no other slot.
- R13: A `cs_n` rise with no store pending leaves `wip` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Reload wipers from slot 0, keep slots |
| cs_n | input | 1 | Chip select, active low; the rising edge commits a pending store |
| wp_n | input | 1 | Write-protect, active low, blocks and cancels stores |
| cmd_valid | input | 1 | Command pulse from the decoder |
| cmd_op | input | 3 | Opcode: 1 wiper write, 2 slot write, 3 slot to wiper, 4 wiper to slot, 5 all slots to wipers, 6 all wipers to slots |
| cmd_ch | input | CH_W (2) | Channel select |
| cmd_reg | input | SL_W (2) | Slot select |
| cmd_data | input | DATA_W (8) | Data for opcodes 1 and 2 |
| rd_ch | input | CH_W (2) | Read port channel |
| rd_reg | input | SL_W (2) | Read port slot |
| rd_data | output | DATA_W (8) | Contents of the addressed slot |
| wiper_o | output | NUM_CH*DATA_W (32) | All wiper values, channel 0 in the low byte |
| wip | output | 1 | Write cycle in progress |

## Verification
The bench builds the block with WRITE_CYCLES set to 6 and DATA_INIT set to 0x5A. The short write time lets it measure the whole busy window edge by edge and still fit many commit, cancel and lock-out sequences into one run. The uncommon initial value makes untouched slots stand apart from zero or stale data. With these values the bench can drop write-protect at each stage of a store (before acceptance, while pending and during the cycle) and see the different results on `wip` and the read port.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [2:0] {
      OP_NOP       = 3'd0,
      OP_WIPER_WR  = 3'd1,
      OP_SLOT_WR   = 3'd2,
      OP_LOAD_ONE  = 3'd3,
      OP_SAVE_ONE  = 3'd4,
      OP_LOAD_ALL  = 3'd5,
      OP_SAVE_ALL  = 3'd6
   } nvs_op_e;
endpackage

// File: rtl/nvs_write_timer.sv
module nvs_write_timer #(
   parameter int WRITE_CYCLES = 1250000,
   parameter bit COMMIT_LATE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic commit_o
);
   localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (WRITE_CYCLES < 1) begin : g_bad_len
         $error("WRITE_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(WRITE_CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   generate
      if (COMMIT_LATE) begin : g_commit_end
         assign commit_o = busy_q && (cnt_q == '0);
      end else begin : g_commit_start
         assign commit_o = start_i;
      end
   endgenerate

   assign busy_o = busy_q;

   AST_WIP_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (busy_q && cnt_q == CNT_W'(WRITE_CYCLES - 1))); // R5
   AST_WIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0 && !start_i) |=> busy_q); // R5
endmodule

// File: rtl/nvs_pending.sv
module nvs_pending #(
   parameter int NUM_CH = 4,
   parameter int SL_W   = 2,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic                     arm_i,
   input  logic [NUM_CH-1:0]        arm_mask_i,
   input  logic [SL_W-1:0]          arm_reg_i,
   input  logic [NUM_CH*DATA_W-1:0] arm_vals_i,
   input  logic                     abort_i,
   input  logic                     take_i,
   output logic                     pend_o,
   output logic [NUM_CH-1:0]        mask_o,
   output logic [SL_W-1:0]          reg_o,
   output logic [NUM_CH*DATA_W-1:0] vals_o
);
   logic                     pend_q;
   logic [NUM_CH-1:0]        mask_q;
   logic [SL_W-1:0]          reg_q;
   logic [NUM_CH*DATA_W-1:0] vals_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pend_q <= 1'b0;
      else if (clr_i || abort_i || take_i) pend_q <= 1'b0;
      else if (arm_i)                      pend_q <= 1'b1;
   end

   // Captured payload stays put through the write cycle: no arm while busy.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         reg_q  <= '0;
         vals_q <= '0;
      end else if (arm_i && !clr_i && !abort_i && !take_i) begin
         mask_q <= arm_mask_i;
         reg_q  <= arm_reg_i;
         vals_q <= arm_vals_i;
      end
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;
   assign reg_o  = reg_q;
   assign vals_o = vals_q;

   AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !pend_q); // R6
endmodule

// File: rtl/nvs_reg_bank.sv
module nvs_reg_bank #(
   parameter int             NUM_CH      = 4,
   parameter int             REGS_PER_CH = 4,
   parameter int             DATA_W      = 8,
   parameter logic [DATA_W-1:0] DATA_INIT = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            soft_rst_i,
   input  logic [NUM_CH-1:0]               wwe_i,
   input  logic                            wsrc_slot_i,
   input  logic [$clog2(REGS_PER_CH)-1:0]  wsel_i,
   input  logic [DATA_W-1:0]               wval_i,
   input  logic                            commit_i,
   input  logic [NUM_CH-1:0]               cmask_i,
   input  logic [$clog2(REGS_PER_CH)-1:0]  creg_i,
   input  logic [NUM_CH*DATA_W-1:0]        cvals_i,
   input  logic [$clog2(NUM_CH)-1:0]       rd_ch_i,
   input  logic [$clog2(REGS_PER_CH)-1:0]  rd_reg_i,
   output logic [DATA_W-1:0]               rd_data_o,
   output logic [NUM_CH*DATA_W-1:0]        wiper_o
);
   localparam int SL_W = $clog2(REGS_PER_CH);

   logic [NUM_CH-1:0][REGS_PER_CH-1:0][DATA_W-1:0] slot_w;
   logic [NUM_CH-1:0][DATA_W-1:0]                  wiper_w;
   logic [NUM_CH-1:0][DATA_W-1:0]                  slot0_w;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [DATA_W-1:0] wiper_q;

         for (genvar r = 0; r < REGS_PER_CH; r++) begin : g_slot
            logic [DATA_W-1:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  cell_q <= DATA_INIT;
               else if (commit_i && cmask_i[c] && creg_i == SL_W'(r))
                  cell_q <= cvals_i[c*DATA_W +: DATA_W];
            end
            assign slot_w[c][r] = cell_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wiper_q <= DATA_INIT;
            else if (soft_rst_i)
               wiper_q <= slot_w[c][0];
            else if (wwe_i[c])
               wiper_q <= wsrc_slot_i ? slot_w[c][wsel_i] : wval_i;
         end

         assign wiper_w[c] = wiper_q;
         assign slot0_w[c] = slot_w[c][0];
      end
   endgenerate

   assign rd_data_o = slot_w[rd_ch_i][rd_reg_i];
   assign wiper_o   = wiper_w;

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(slot_w)); // R4
   AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst_i && !commit_i) |=> (wiper_w == $past(slot0_w))); // R2
endmodule

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl
   import nvs_pkg::*;
#(
   parameter int             NUM_CH       = 4,
   parameter int             REGS_PER_CH  = 4,
   parameter int             DATA_W       = 8,
   parameter int             WRITE_CYCLES = 1250000,
   parameter logic [DATA_W-1:0] DATA_INIT = 8'h80,
   parameter bit             COMMIT_LATE  = 1'b1,
   localparam int            CH_W = $clog2(NUM_CH),
   localparam int            SL_W = $clog2(REGS_PER_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     soft_rst,
   input  logic                     cs_n,
   input  logic                     wp_n,
   input  logic                     cmd_valid,
   input  logic [2:0]               cmd_op,
   input  logic [CH_W-1:0]          cmd_ch,
   input  logic [SL_W-1:0]          cmd_reg,
   input  logic [DATA_W-1:0]        cmd_data,
   input  logic [CH_W-1:0]          rd_ch,
   input  logic [SL_W-1:0]          rd_reg,
   output logic [DATA_W-1:0]        rd_data,
   output logic [NUM_CH*DATA_W-1:0] wiper_o,
   output logic                     wip
);
   generate
      if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
         $error("NUM_CH must be a power of two, at least 2");
      end
      if (REGS_PER_CH < 2 || (1 << SL_W) != REGS_PER_CH) begin : g_bad_sl
         $error("REGS_PER_CH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be positive");
      end
   endgenerate

   logic                     cs_q;
   logic                     cs_rise;
   logic                     busy;
   logic                     commit;
   logic                     pend;
   logic [NUM_CH-1:0]        pmask;
   logic [SL_W-1:0]          preg;
   logic [NUM_CH*DATA_W-1:0] pvals;
   logic                     is_store;
   logic                     arm;
   logic                     abort;
   logic                     start;
   logic [NUM_CH-1:0]        arm_mask;
   logic [NUM_CH*DATA_W-1:0] arm_vals;
   logic [NUM_CH-1:0]        wwe;
   logic                     wsrc_slot;
   logic [NUM_CH-1:0]        ch_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q <= 1'b1;
      else        cs_q <= cs_n;
   end
   assign cs_rise = cs_n && !cs_q;

   assign ch_sel = NUM_CH'(1) << cmd_ch;

   always_comb begin
      is_store  = 1'b0;
      arm_mask  = '0;
      arm_vals  = wiper_o;
      wwe       = '0;
      wsrc_slot = 1'b0;
      if (cmd_valid) begin
         case (nvs_op_e'(cmd_op))
            OP_WIPER_WR: wwe = ch_sel;
            OP_LOAD_ONE: begin wwe = ch_sel;    wsrc_slot = 1'b1; end
            OP_LOAD_ALL: begin wwe = '1;        wsrc_slot = 1'b1; end
            OP_SLOT_WR: begin
               is_store = 1'b1;
               arm_mask = ch_sel;
               arm_vals = {NUM_CH{cmd_data}};
            end
            OP_SAVE_ONE: begin is_store = 1'b1; arm_mask = ch_sel; end
            OP_SAVE_ALL: begin is_store = 1'b1; arm_mask = '1;     end
            default: ;
         endcase
      end
   end

   assign arm   = is_store && wp_n && !cs_n && !busy;
   assign abort = pend && !wp_n;
   assign start = cs_rise && pend && wp_n && !busy;

   nvs_pending #(
      .NUM_CH (NUM_CH),
      .SL_W   (SL_W),
      .DATA_W (DATA_W)
   ) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (soft_rst),
      .arm_i      (arm),
      .arm_mask_i (arm_mask),
      .arm_reg_i  (cmd_reg),
      .arm_vals_i (arm_vals),
      .abort_i    (abort),
      .take_i     (start),
      .pend_o     (pend),
      .mask_o     (pmask),
      .reg_o      (preg),
      .vals_o     (pvals)
   );

   nvs_write_timer #(
      .WRITE_CYCLES (WRITE_CYCLES),
      .COMMIT_LATE  (COMMIT_LATE)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .busy_o   (busy),
      .commit_o (commit)
   );

   nvs_reg_bank #(
      .NUM_CH      (NUM_CH),
      .REGS_PER_CH (REGS_PER_CH),
      .DATA_W      (DATA_W),
      .DATA_INIT   (DATA_INIT)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst_i  (soft_rst),
      .wwe_i       (wwe),
      .wsrc_slot_i (wsrc_slot),
      .wsel_i      (cmd_reg),
      .wval_i      (cmd_data),
      .commit_i    (commit),
      .cmask_i     (pmask),
      .creg_i      (preg),
      .cvals_i     (pvals),
      .rd_ch_i     (rd_ch),
      .rd_reg_i    (rd_reg),
      .rd_data_o   (rd_data),
      .wiper_o     (wiper_o)
   );

   assign wip = busy;

   AST_WP_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n |=> !pend); // R6
   AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !pend); // R8
   AST_IDLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && !pend && !busy) |=> !busy); // R13
endmodule

// File: tb/nvstore_ctrl_tb.sv
module nvstore_ctrl_tb;
   localparam int          WC = 6;
   localparam logic [7:0]  DI = 8'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       cs_n = 1'b1;
   logic       wp_n = 1'b1;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [1:0] cmd_ch = 2'd0;
   logic [1:0] cmd_reg = 2'd0;
   logic [7:0] cmd_data = 8'd0;
   logic [1:0] rd_ch = 2'd0;
   logic [1:0] rd_reg = 2'd0;
   logic [7:0] rd_data;
   logic [31:0] wiper_o;
   logic       wip;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   nvstore_ctrl #(.WRITE_CYCLES(WC), .DATA_INIT(DI)) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cs_n(cs_n), .wp_n(wp_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_reg(cmd_reg),
      .cmd_data(cmd_data), .rd_ch(rd_ch), .rd_reg(rd_reg), .rd_data(rd_data),
      .wiper_o(wiper_o), .wip(wip));

   // Wiper-write vectors: {wp_n, ch[1:0], data[7:0]}
   localparam logic [10:0] VEC [8] = '{
      {1'b1, 2'd0, 8'h01}, {1'b1, 2'd1, 8'hFE}, {1'b0, 2'd2, 8'h33},
      {1'b1, 2'd3, 8'hC4}, {1'b0, 2'd0, 8'h00}, {1'b1, 2'd2, 8'hFF},
      {1'b0, 2'd1, 8'h7E}, {1'b1, 2'd3, 8'h18}};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic issue(input logic [2:0] op, input logic [1:0] ch,
                        input logic [1:0] rg, input logic [7:0] d);
      cmd_op = op; cmd_ch = ch; cmd_reg = rg; cmd_data = d; cmd_valid = 1'b1;
      tick();
      cmd_valid = 1'b0;
   endtask

   task automatic rd(input logic [1:0] ch, input logic [1:0] rg, output logic [7:0] v);
      rd_ch = ch; rd_reg = rg;
      #1;
      v = rd_data;
   endtask

   function automatic logic [7:0] wp_of(input int c);
      return wiper_o[c*8 +: 8];
   endfunction

   // Store frame: cs low, command, cs high; leaves the bench after the cs-rise edge.
   task automatic store_frame(input logic [2:0] op, input logic [1:0] ch,
                              input logic [1:0] rg, input logic [7:0] d);
      cs_n = 1'b0; tick();
      issue(op, ch, rg, d);
      cs_n = 1'b1; tick();
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (wip === 1'b1 && n < 1000) begin n++; tick(); end
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] exp_w [4];
      int n;

      tick(); tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      chk("R1 wip after reset", wip, 0);
      for (int c = 0; c < 4; c++) begin
         chk("R1 wiper init", wp_of(c), DI);
         exp_w[c] = DI;
         for (int r = 0; r < 4; r++) begin
            rd(c[1:0], r[1:0], v);
            chk("R1 slot init", v, DI);
         end
      end

      // R3: table of wiper writes, some with write-protect active
      for (int i = 0; i < 8; i++) begin
         wp_n = VEC[i][10];
         issue(3'd1, VEC[i][9:8], 2'd0, VEC[i][7:0]);
         exp_w[VEC[i][9:8]] = VEC[i][7:0];
         for (int c = 0; c < 4; c++) chk("R3 wiper write", wp_of(c), exp_w[c]);
      end
      wp_n = 1'b1;

      // R4 / R5: slot write held until cs rises, then timed cycle
      cs_n = 1'b0; tick();
      issue(3'd2, 2'd2, 2'd1, 8'h3C);
      tick(); tick();
      rd(2'd2, 2'd1, v);
      chk("R4 slot unchanged before cs rise", v, DI);
      chk("R4 wip low before cs rise", wip, 0);
      cs_n = 1'b1; tick();
      chk("R5 wip rises with cs", wip, 1);
      rd(2'd2, 2'd1, v);
      chk("R5 slot not yet written", v, DI);
      wait_idle(n);
      chk("R5 busy length", n, WC);
      rd(2'd2, 2'd1, v);
      chk("R5 slot written", v, 8'h3C);

      // R13: empty frame
      cs_n = 1'b0; tick(); cs_n = 1'b1; tick();
      chk("R13 no cycle without pending store", wip, 0);

      // R6: store sampled under write-protect
      wp_n = 1'b0;
      store_frame(3'd2, 2'd0, 2'd2, 8'h11);
      chk("R6 protected store no cycle", wip, 0);
      wp_n = 1'b1;
      rd(2'd0, 2'd2, v);
      chk("R6 protected store slot", v, DI);

      // R6: write-protect pulse while pending cancels
      cs_n = 1'b0; tick();
      issue(3'd2, 2'd1, 2'd3, 8'h22);
      wp_n = 1'b0; tick(); wp_n = 1'b1; tick();
      cs_n = 1'b1; tick();
      chk("R6 cancelled store no cycle", wip, 0);
      rd(2'd1, 2'd3, v);
      chk("R6 cancelled store slot", v, DI);

      // R7: write-protect during cycle has no effect
      store_frame(3'd2, 2'd3, 2'd0, 8'h77);
      chk("R7 cycle started", wip, 1);
      wp_n = 1'b0;
      wait_idle(n);
      wp_n = 1'b1;
      chk("R7 busy length under protect", n, WC);
      rd(2'd3, 2'd0, v);
      chk("R7 slot written under protect", v, 8'h77);

      // R8: store during cycle ignored; R3 wiper write during cycle allowed
      store_frame(3'd2, 2'd0, 2'd0, 8'h44);
      cs_n = 1'b0; tick();
      issue(3'd2, 2'd0, 2'd1, 8'h99);
      issue(3'd1, 2'd1, 2'd0, 8'h31);
      exp_w[1] = 8'h31;
      chk("R3 wiper write while busy", wp_of(1), 8'h31);
      cs_n = 1'b1; tick();
      wait_idle(n);
      tick(); tick();
      chk("R8 no second cycle", wip, 0);
      rd(2'd0, 2'd1, v);
      chk("R8 ignored store slot", v, DI);
      rd(2'd0, 2'd0, v);
      chk("R5 first store landed", v, 8'h44);

      // R9: single slot to wiper
      issue(3'd3, 2'd2, 2'd1, 8'h00);
      chk("R9 load one wiper", wp_of(2), 8'h3C);
      chk("R9 no cycle", wip, 0);
      chk("R9 other wiper kept", wp_of(1), 8'h31);

      // R10: all slots 0 to wipers
      issue(3'd5, 2'd0, 2'd0, 8'h00);
      chk("R10 ch0", wp_of(0), 8'h44);
      chk("R10 ch1", wp_of(1), DI);
      chk("R10 ch2", wp_of(2), DI);
      chk("R10 ch3", wp_of(3), 8'h77);
      chk("R10 no cycle", wip, 0);

      // R12: single wiper to slot
      issue(3'd1, 2'd1, 2'd0, 8'hA1);
      store_frame(3'd4, 2'd1, 2'd2, 8'h00);
      wait_idle(n);
      rd(2'd1, 2'd2, v);
      chk("R12 saved wiper", v, 8'hA1);
      rd(2'd0, 2'd2, v);
      chk("R12 other channel untouched", v, DI);

      // R11: all wipers to slot 3
      for (int c = 0; c < 4; c++) issue(3'd1, c[1:0], 2'd0, 8'h10 * (c + 1));
      store_frame(3'd6, 2'd0, 2'd3, 8'h00);
      wait_idle(n);
      chk("R11 busy length", n, WC);
      for (int c = 0; c < 4; c++) begin
         rd(c[1:0], 2'd3, v);
         chk("R11 saved all", v, 8'h10 * (c + 1));
      end

      // R2: soft reset reloads wipers from slot 0, slots kept
      for (int c = 0; c < 4; c++) issue(3'd1, c[1:0], 2'd0, 8'hEE);
      soft_rst = 1'b1; tick(); soft_rst = 1'b0;
      chk("R2 ch0", wp_of(0), 8'h44);
      chk("R2 ch1", wp_of(1), DI);
      chk("R2 ch2", wp_of(2), DI);
      chk("R2 ch3", wp_of(3), 8'h77);
      rd(2'd2, 2'd1, v);
      chk("R2 slot kept", v, 8'h3C);
      rd(2'd2, 2'd3, v);
      chk("R2 slot kept", v, 8'h30);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule